// File: doc/BRIEF.md
# Configurable Convolutional Encoder

This block turns a serial stream of information bits into convolutionally coded words at rate 1/2, 1/3 or 1/4. The constraint length can be changed at run time to any value from 5 to 9. Each output lane uses its own 8-bit generator word. One information bit is taken per handshake, and one coded word of 2 to 4 bits is produced one cycle later through a registered valid/ready output stage.

A frame starts with a configuration load. The load sets the constraint length, the rate and the generator words, and it clears the encoder memory to zero. To close a frame, software pulses a flush. The block then feeds K-1 zero bits through the code on its own, so that the trellis returns to state 0. The last of these tail words is marked. The block is intended as a stimulus source for testing a Viterbi decoder.

Top module: `cfg_conv_encoder`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1. The active configuration is K=9, rate code 0 and all generator words zero, so each coded word repeats the input bit in lanes 0 and 1.
- R2: A cfg_load takes effect at the next edge when it is legal and no tail is running. Legal means cfg_k is in 5..9 and cfg_rate is 0 (2 lanes), 1 (3 lanes) or 2 (4 lanes). The load replaces K, the rate and the generator words, and it clears the encoder memory to zero. in_ready is 0 in that cycle.
- R3: A cfg_load with cfg_k outside 5..9, or with cfg_rate equal to 3, is ignored. The configuration and the encoder memory stay as they were.
- R4: Coded bit i is the current input bit XOR the parity of (cfg_gen[8i+j] AND the input accepted j+1 beats earlier), taken over j = 0..K-2. Taps at j >= K-1 have no effect.
- R5: Bit i of out_bits carries generator i, with lane 0 in the least significant position. Bits at positions equal to or above the lane count of the rate are 0.
- R6: Every accepted input bit yields exactly one coded word. That word appears with out_valid=1 in the cycle after the accepting edge.
- R7: While out_valid=1 and out_ready=0, out_bits and out_last hold steady. in_ready is 1 exactly when no tail is running, the output stage is free (out_valid=0 or out_ready=1) and no legal cfg_load is accepted in that cycle.
- R8: A flush pulse while no tail is running produces exactly K-1 coded words with a zero input bit. Only the last of them has out_last=1, and in_ready stays 0 until the last one is loaded.
- R9: After the tail, the encoder memory is zero. Later bits encode as if the frame had just been loaded.
- R10: A flush or a cfg_load arriving while a tail is running is ignored.
- R11: A flush in the same cycle as an accepted data bit takes that bit first. The tail follows, with its length taken from the K in effect after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration load strobe, also starts a frame |
| cfg_k | input | 4 | Constraint length value |
| cfg_rate | input | 2 | Rate code: 0 = 1/2, 1 = 1/3, 2 = 1/4 |
| cfg_gen | input | 32 | Four 8-bit generator words, lane i in bits 8i+7..8i |
| flush | input | 1 | Start of the zero tail |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted when high together with in_valid |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Coded word valid |
| out_ready | input | 1 | Downstream can take the coded word |
| out_bits | output | 4 | Coded word, lane 0 in the LSB |
| out_last | output | 1 | Marks the final tail word |

## Verification
An error in the encoder memory shows up within one coded word. The next word computed from the corrupted tap differs in every lane whose generator selects that tap. The error then keeps showing for up to K-1 words, until the bad bit shifts out of range. A wrong tail counter is seen at the handshake pins instead. in_ready rises too early or too late, or out_last lands on the wrong word, and the reference model catches this on the first cycle it happens. To expose taps that lanes with zero generator bits would hide, the bench uses random generator words, every legal K, and random backpressure.

// File: rtl/cenc_pkg.sv
package cenc_pkg;

   typedef enum logic [1:0] {
      RATE_1_2 = 2'd0,
      RATE_1_3 = 2'd1,
      RATE_1_4 = 2'd2,
      RATE_BAD = 2'd3
   } rate_e;

   // number of coded lanes produced for a rate code
   function automatic int lanes_for(rate_e r);
      return int'(r) + 2;
   endfunction

endpackage

// File: rtl/cenc_cfg.sv
module cenc_cfg
   import cenc_pkg::*;
#(
   parameter int MAX_K   = 9,
   parameter int MIN_K   = 5,
   parameter int MAX_OUT = 4,
   parameter int RST_K   = 9,
   localparam int KW     = $clog2(MAX_K + 1),
   localparam int SR_W   = MAX_K - 1,
   localparam int GEN_W  = MAX_OUT * SR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [KW-1:0]      k_in,
   input  logic [1:0]         rate_in,
   input  logic [GEN_W-1:0]   gen_in,
   input  logic               busy,
   output logic               accept,
   output logic [KW-1:0]      k_next,
   output logic [SR_W-1:0]    tap_mask,
   output logic [MAX_OUT-1:0] lane_mask,
   output logic [GEN_W-1:0]   gen_q
);

   logic [KW-1:0] k_q;
   rate_e         rate_q;
   logic          legal;

   always_comb begin
      legal = (k_in >= KW'(MIN_K)) && (k_in <= KW'(MAX_K)) &&
              (rate_e'(rate_in) != RATE_BAD) &&
              (lanes_for(rate_e'(rate_in)) <= MAX_OUT);
   end

   assign accept = load && legal && !busy;
   assign k_next = accept ? k_in : k_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q    <= KW'(RST_K);
         rate_q <= RATE_1_2;
         gen_q  <= '0;
      end else if (accept) begin
         k_q    <= k_in;
         rate_q <= rate_e'(rate_in);
         gen_q  <= gen_in;
      end
   end

   // tap j (delay j+1) is live while j+1 < K
   for (genvar j = 0; j < SR_W; j++) begin : g_tap
      assign tap_mask[j] = (k_q > KW'(j + 1));
   end

   for (genvar i = 0; i < MAX_OUT; i++) begin : g_lane
      assign lane_mask[i] = (lanes_for(rate_q) > i);
   end

   // R3: rejected loads leave the configuration unchanged
   p_illegal_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !legal) |=> ($stable(k_q) && $stable(rate_q) && $stable(gen_q)));

   // R10: no configuration change while a tail is running
   p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(k_q) && $stable(gen_q)));

endmodule

// File: rtl/cenc_shift.sv
module cenc_shift #(
   parameter int SR_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            shift,
   input  logic            din,
   output logic [SR_W-1:0] state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= '0;
      else if (clr)
         state <= '0;
      else if (shift)
         state <= {state[SR_W-2:0], din};
   end

   // R2: frame start empties the encoder memory
   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == '0));

   // R4: newest accepted bit sits at delay one
   p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !clr) |=> (state[0] == $past(din)));

endmodule

// File: rtl/cenc_lanes.sv
module cenc_lanes #(
   parameter int SR_W    = 8,
   parameter int MAX_OUT = 4,
   localparam int GEN_W  = MAX_OUT * SR_W
) (
   input  logic               cur,
   input  logic [SR_W-1:0]    state,
   input  logic [SR_W-1:0]    tap_mask,
   input  logic [MAX_OUT-1:0] lane_mask,
   input  logic [GEN_W-1:0]   gen,
   output logic [MAX_OUT-1:0] code
);

   logic [SR_W-1:0] live;
   assign live = state & tap_mask;

   for (genvar i = 0; i < MAX_OUT; i++) begin : g_par
      logic [SR_W-1:0] sel;
      assign sel     = gen[i*SR_W +: SR_W] & live;
      assign code[i] = lane_mask[i] & (cur ^ (^sel));
   end

endmodule

// File: rtl/cenc_tail.sv
module cenc_tail #(
   parameter int KW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [KW-1:0] k_next,
   input  logic          tail_step,
   output logic          active,
   output logic          final_beat
);

   logic [KW-1:0] left;

   assign active     = (left != '0);
   assign final_beat = (left == KW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (!active && flush)
         left <= k_next - KW'(1);
      else if (active && tail_step)
         left <= left - KW'(1);
   end

   // R8: the last tail word ends the tail
   p_tail_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tail_step && final_beat) |=> !active);

   // R10: a stalled tail neither restarts nor advances
   p_tail_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tail_step) |=> $stable(left));

endmodule

// File: rtl/cfg_conv_encoder.sv
module cfg_conv_encoder #(
   parameter int MAX_K   = 9,
   parameter int MIN_K   = 5,
   parameter int MAX_OUT = 4,
   parameter int RST_K   = 9,
   localparam int KW     = $clog2(MAX_K + 1),
   localparam int SR_W   = MAX_K - 1,
   localparam int GEN_W  = MAX_OUT * SR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [KW-1:0]      cfg_k,
   input  logic [1:0]         cfg_rate,
   input  logic [GEN_W-1:0]   cfg_gen,
   input  logic               flush,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               in_bit,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [MAX_OUT-1:0] out_bits,
   output logic               out_last
);

   if (MIN_K < 2 || MAX_K < MIN_K) begin : g_bad_k
      $error("cfg_conv_encoder: constraint length range is empty");
   end
   if (RST_K < MIN_K || RST_K > MAX_K) begin : g_bad_rst
      $error("cfg_conv_encoder: reset K outside legal range");
   end
   if (MAX_OUT < 2 || MAX_OUT > 4) begin : g_bad_out
      $error("cfg_conv_encoder: lane count must be 2 to 4");
   end

   logic               cfg_accept;
   logic [KW-1:0]      k_next;
   logic [SR_W-1:0]    tap_mask;
   logic [MAX_OUT-1:0] lane_mask;
   logic [GEN_W-1:0]   gen_q;
   logic [SR_W-1:0]    state;
   logic [MAX_OUT-1:0] code;
   logic               tail_active, tail_final;
   logic               slot, data_acc, tail_step, step, cur_bit;

   assign slot      = !out_valid || out_ready;
   assign in_ready  = !tail_active && slot && !cfg_accept;
   assign data_acc  = in_valid && in_ready;
   assign tail_step = tail_active && slot;
   assign step      = data_acc || tail_step;
   assign cur_bit   = tail_active ? 1'b0 : in_bit;

   cenc_cfg #(
      .MAX_K(MAX_K), .MIN_K(MIN_K), .MAX_OUT(MAX_OUT), .RST_K(RST_K)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .k_in(cfg_k),
      .rate_in(cfg_rate), .gen_in(cfg_gen), .busy(tail_active),
      .accept(cfg_accept), .k_next(k_next), .tap_mask(tap_mask),
      .lane_mask(lane_mask), .gen_q(gen_q)
   );

   cenc_shift #(.SR_W(SR_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(cfg_accept), .shift(step),
      .din(cur_bit), .state(state)
   );

   cenc_lanes #(.SR_W(SR_W), .MAX_OUT(MAX_OUT)) u_lanes (
      .cur(cur_bit), .state(state), .tap_mask(tap_mask),
      .lane_mask(lane_mask), .gen(gen_q), .code(code)
   );

   cenc_tail #(.KW(KW)) u_tail (
      .clk(clk), .rst_n(rst_n), .flush(flush), .k_next(k_next),
      .tail_step(tail_step), .active(tail_active), .final_beat(tail_final)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_bits  <= '0;
         out_last  <= 1'b0;
      end else if (step) begin
         out_valid <= 1'b1;
         out_bits  <= code;
         out_last  <= tail_step && tail_final;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R7: a stalled word is held unchanged
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_last)));

   // R6: an accepted bit is presented on the next cycle
   p_accept_emits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !out_last));

   // R8: no input is taken while the tail runs
   p_tail_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> $past(!in_ready));

endmodule

// File: tb/cfg_conv_encoder_test.sv
module cfg_conv_encoder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic [3:0] cfg_k = 4'd0;
   logic [1:0] cfg_rate = 2'd0;
   logic [31:0] cfg_gen = 32'd0;
   logic       flush = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_bit = 1'b0;
   logic       out_ready = 1'b1;
   logic       in_ready, out_valid, out_last;
   logic [3:0] out_bits;

   always #4 clk = ~clk;

   cfg_conv_encoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_k(cfg_k),
      .cfg_rate(cfg_rate), .cfg_gen(cfg_gen), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
      .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
      .out_last(out_last)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   bit    stall = 1'b0;
   string scen = "R1";

   // behavioural reference state
   int         mk = 9;
   int         mn = 2;
   logic [7:0] mgen [4];
   logic [7:0] mhist = 8'd0;
   int         mtail = 0;

   typedef struct {
      logic [3:0] bits;
      logic       last;
      int         lanes;
      string      tag;
   } beat_t;
   beat_t q[$];

   initial for (int i = 0; i < 4; i++) mgen[i] = 8'd0;

   function automatic logic [3:0] menc(logic b);
      logic [3:0] r = 4'd0;
      for (int i = 0; i < mn; i++) begin
         logic v = b;
         for (int j = 0; j < mk - 1; j++) v = v ^ (mgen[i][j] & mhist[j]);
         r[i] = v;
      end
      return r;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model, evaluated between edges for the edge that follows
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit slot, legal, exp_rdy;
         int old_tail;
         beat_t nb;
         slot    = !out_valid || out_ready;
         legal   = cfg_load && (mtail == 0) && (cfg_k >= 4'd5) && (cfg_k <= 4'd9)
                   && (cfg_rate != 2'd3);
         exp_rdy = (mtail == 0) && slot && !legal;
         chk(in_ready == exp_rdy, "R7", "in_ready", in_ready, exp_rdy);
         chk(out_valid == (q.size() != 0), "R6", "out_valid", out_valid, q.size() != 0);
         if (out_valid && q.size() != 0) begin
            chk(out_bits == q[0].bits, q[0].tag, "out_bits", out_bits, q[0].bits);
            chk(out_last == q[0].last, "R8", "out_last", out_last, q[0].last);
            chk((out_bits >> q[0].lanes) == 4'd0, "R5", "unused lanes",
                out_bits >> q[0].lanes, 0);
            if (out_ready) void'(q.pop_front());
         end
         if (legal) begin
            mk = int'(cfg_k);
            mn = int'(cfg_rate) + 2;
            for (int i = 0; i < 4; i++) mgen[i] = cfg_gen[8*i +: 8];
            mhist = 8'd0;
         end
         old_tail = mtail;
         if (in_valid && exp_rdy) begin
            nb.bits = menc(in_bit); nb.last = 1'b0; nb.lanes = mn;
            nb.tag = {"R4 ", scen};
            q.push_back(nb);
            mhist = {mhist[6:0], in_bit};
         end else if (old_tail > 0 && slot) begin
            nb.bits = menc(1'b0); nb.last = (old_tail == 1); nb.lanes = mn;
            nb.tag = {"R8 ", scen};
            q.push_back(nb);
            mhist = {mhist[6:0], 1'b0};
            mtail = mtail - 1;
         end
         if (flush && old_tail == 0) mtail = mk - 1;
      end
   end

   // downstream backpressure
   initial begin
      forever begin
         @(posedge clk);
         #1 out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   task automatic load(int k, int rate, logic [31:0] g);
      @(posedge clk); #1;
      cfg_load = 1'b1; cfg_k = 4'(k); cfg_rate = 2'(rate); cfg_gen = g;
      @(posedge clk); #1;
      cfg_load = 1'b0;
   endtask

   task automatic send(logic b);
      @(posedge clk); #1;
      in_valid = 1'b1; in_bit = b;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic send_n(int n);
      for (int i = 0; i < n; i++) send(1'($urandom_range(0, 1)));
   endtask

   task automatic pulse_flush();
      @(posedge clk); #1 flush = 1'b1;
      @(posedge clk); #1 flush = 1'b0;
   endtask

   task automatic drain();
      repeat (24) @(posedge clk);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
      chk(out_last == 1'b0, "R1", "reset out_last", out_last, 0);

      scen = "R1"; send(1'b1); send(1'b0); send(1'b1); drain();

      scen = "R2"; load(7, 0, $urandom()); send_n(40); drain();
      scen = "R4"; load(5, 1, $urandom()); send_n(30);
      load(9, 2, $urandom()); send_n(40);
      load(6, 2, $urandom()); send_n(30);
      load(8, 1, $urandom()); send_n(30); drain();

      scen = "R7"; stall = 1'b1; send_n(60); stall = 1'b0; drain();

      scen = "R8"; load(9, 2, $urandom()); send_n(20); pulse_flush(); drain();
      scen = "R9"; send_n(20);
      stall = 1'b1; pulse_flush(); drain(); send_n(15); stall = 1'b0; drain();

      scen = "R10"; pulse_flush();
      @(posedge clk); #1;
      flush = 1'b1; cfg_load = 1'b1; cfg_k = 4'd6; cfg_rate = 2'd0; cfg_gen = $urandom();
      @(posedge clk); #1;
      flush = 1'b0; cfg_load = 1'b0;
      drain(); send_n(20); drain();

      scen = "R3"; load(4, 1, $urandom()); send_n(12);
      load(10, 0, $urandom()); send_n(12);
      load(7, 3, $urandom()); send_n(12); drain();

      scen = "R11"; load(5, 0, $urandom()); send_n(6); drain();
      @(posedge clk); #1;
      in_valid = 1'b1; in_bit = 1'b1; flush = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R11", "beat with flush taken", in_ready, 1);
      @(posedge clk); #1;
      in_valid = 1'b0; flush = 1'b0;
      drain(); send_n(10); drain();

      summary();
      $finish;
   end

endmodule